// File: doc/BRIEF.md
# Rotation-Marker Lane Deinterleaver

This block sits on the receive side of a link that carries several low-rate lanes time-interleaved into one character stream. Each cycle it accepts at most one already-decoded character. A rotation marker in the stream shows where a frame starts. The block sends each character to the output lane that matches its source lane, one character per lane per frame. The transmitter puts the marker in place of the normal comma character on the home lane. The receiver turns the marker back into that comma before the home lane sees it.

Realignment takes effect at once and has no hysteresis. Any marker that is accepted restarts the frame at the home lane. A spurious marker therefore shifts the lane mapping until the next genuine marker arrives. The block then publishes the partial frame it has collected. Lanes that got no new character in that frame keep their previous value, so each lane takes at most one wrong character. Until the first marker arrives, the block holds every lane at the idle character and discards the input.

Top module: `lane_deinterleaver`

## Requirements
- R1: After reset, and until the first marker, `locked` is low, `lane_valid` is zero and every lane shows the idle character K28.5 (9'h1BC). Characters that arrive before the first marker have no effect on the outputs.
- R2: A K28.3 rotation marker is a character with bit 8 (control flag) set and bits 7:0 equal to 8'h7C (9'h17C). The first marker sets `locked` one cycle later, and `locked` then stays high until reset.
- R3: The marker maps to the home lane (lane 0 by default). Each following accepted character goes to the next higher lane. Lane i is `lane_data[9*i +: 9]`. When lane NLANES-1 is written, the whole frame appears on `lane_data` in the next cycle, and `lane_valid` is all ones for that single cycle.
- R4: Every marker that causes a realignment appears on the home lane as K28.5 (9'h1BC), never as K28.3.
- R5: A K28.3 that is the first accepted character after a realigning marker is not a marker. It is passed through unchanged as data on the lane after the home lane.
- R6: Any other K28.3 realigns at once. If the current frame already holds characters, those characters are published in the next cycle. `lane_valid` marks only the lanes that received a character, and every other lane repeats its previous character.
- R7: A new rotation stays in force until the next realigning marker. Characters after a spurious marker fill the lanes after the home lane in order. A frame with no marker continues the rotation from lane 0.
- R8: `lane_data` changes only in a cycle where `lane_valid` is non-zero, and `lane_valid` returns to zero in the cycle after each publish.
- R9: A cycle with `in_valid` low neither advances the lane position nor changes any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A character is present on `in_char` this cycle |
| in_char | input | 9 | Decoded character: bit 8 control flag, bits 7:0 value |
| lane_data | output | NLANES*9 | Output lanes; lane i occupies bits 9*i+8 down to 9*i |
| lane_valid | output | NLANES | One-cycle mask of lanes refreshed by the latest publish |
| locked | output | 1 | High once the first marker has been seen |

## Verification
The checker tests on every cycle the properties that need no knowledge of frame content. These are the idle outputs while unlocked, the sticky lock and the lock set by any marker. It also checks that the lane outputs stay put without a valid pulse, and that a publish that includes the last lane also includes the home lane. Only the scoreboard scenarios can show the actual lane mapping. These include marker restoration, the pass-through of a K28.3 right after a marker, and the two partial frames produced by a spurious marker, where stale characters are repeated and shifted characters cross lanes. Stall cycles and a frame without a marker that continues the rotation also need the scenarios, because the right values depend on the history of the stream.

// File: rtl/lane_deinterleaver_pkg.sv
package lane_deinterleaver_pkg;

    localparam int CHAR_W = 9;

    typedef logic [CHAR_W-1:0] char_t;

    // control flag in bit 8, code byte below it
    localparam char_t COMMA_CHAR = 9'h1BC;  // K28.5, also the idle fill
    localparam char_t ROT_MARK   = 9'h17C;  // K28.3 rotation marker

    function automatic logic is_rot_mark(input char_t c);
        return c == ROT_MARK;
    endfunction

endpackage

// File: rtl/lane_deinterleaver_mark_det.sv
module lane_deinterleaver_mark_det
    import lane_deinterleaver_pkg::*;
(
    input  char_t in_char,
    output char_t restored_char,
    output logic  is_marker
);

    // Classify the incoming character; the restored form is what the home
    // lane receives if the marker is accepted.
    always_comb begin
        is_marker     = is_rot_mark(in_char);
        restored_char = is_marker ? COMMA_CHAR : in_char;
    end

endmodule

// File: rtl/lane_deinterleaver_align.sv
module lane_deinterleaver_align #(
    parameter int NLANES    = 8,
    parameter int HOME_LANE = 0,
    localparam int SLOT_W   = (NLANES > 1) ? $clog2(NLANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              is_marker,
    output logic              realign,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic              locked
);

    localparam logic [SLOT_W-1:0] HOME_SLOT = SLOT_W'(HOME_LANE);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NLANES - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;        // lane the next character lands on
        logic              locked;
        logic              after_mark;  // last accepted char was a realign
    } align_st_t;

    align_st_t st_d, st_q;
    logic      skip_mark;

    always_comb begin
        st_d      = st_q;
        // a marker directly behind a realigning one is plain data
        skip_mark = is_marker && st_q.after_mark;
        realign   = in_valid && is_marker && !skip_mark;
        wr_en     = in_valid && (st_q.locked || realign);
        wr_slot   = realign ? HOME_SLOT : st_q.slot;

        if (wr_en) begin
            st_d.slot       = (wr_slot == LAST_SLOT) ? '0 : wr_slot + 1'b1;
            st_d.after_mark = realign;
        end
        if (realign) begin
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;

endmodule

// File: rtl/lane_deinterleaver_stage.sv
module lane_deinterleaver_stage
    import lane_deinterleaver_pkg::*;
#(
    parameter int NLANES  = 8,
    localparam int SLOT_W = (NLANES > 1) ? $clog2(NLANES) : 1,
    localparam int DATA_W = NLANES * CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              realign,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  char_t             wr_char,
    output logic [DATA_W-1:0] lane_data,
    output logic [NLANES-1:0] lane_valid
);

    typedef struct packed {
        logic [NLANES-1:0][CHAR_W-1:0] stage;    // frame under assembly
        logic [NLANES-1:0][CHAR_W-1:0] out;      // last published frame
        logic [NLANES-1:0]             written;  // lanes filled this frame
        logic [NLANES-1:0]             valid;    // publish pulse
    } stage_st_t;

    stage_st_t         st_d, st_q;
    logic [NLANES-1:0] hit;
    logic              cut, close;

    for (genvar g = 0; g < NLANES; g++) begin : g_hit
        assign hit[g] = wr_en && (wr_slot == SLOT_W'(g));
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = '0;
        // a realign with characters pending closes the partial frame first
        cut        = realign && (|st_q.written);
        close      = hit[NLANES-1];

        for (int i = 0; i < NLANES; i++) begin
            if (hit[i]) begin
                st_d.stage[i] = wr_char;
            end
        end

        if (cut) begin
            st_d.out     = st_q.stage;
            st_d.valid   = st_q.written;
            st_d.written = hit;
        end else if (close) begin
            st_d.out     = st_d.stage;
            st_d.valid   = st_q.written | hit;
            st_d.written = '0;
        end else begin
            st_d.written = st_q.written | hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLANES; i++) begin
                st_q.stage[i] <= COMMA_CHAR;
                st_q.out[i]   <= COMMA_CHAR;
            end
            st_q.written <= '0;
            st_q.valid   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lane_data  = st_q.out;
    assign lane_valid = st_q.valid;

endmodule

// File: rtl/lane_deinterleaver.sv
module lane_deinterleaver
    import lane_deinterleaver_pkg::*;
#(
    parameter int NLANES    = 8,   // lanes per frame
    parameter int HOME_LANE = 0,   // marker lane, below NLANES-1
    localparam int SLOT_W   = (NLANES > 1) ? $clog2(NLANES) : 1,
    localparam int DATA_W   = NLANES * CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [8:0]        in_char,
    output logic [DATA_W-1:0] lane_data,
    output logic [NLANES-1:0] lane_valid,
    output logic              locked
);

    char_t             restored_char, wr_char;
    logic              is_marker, realign, wr_en;
    logic [SLOT_W-1:0] wr_slot;

    lane_deinterleaver_mark_det u_det (
        .in_char       (in_char),
        .restored_char (restored_char),
        .is_marker     (is_marker)
    );

    lane_deinterleaver_align #(
        .NLANES    (NLANES),
        .HOME_LANE (HOME_LANE)
    ) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .is_marker (is_marker),
        .realign   (realign),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .locked    (locked)
    );

    // only an accepted marker is restored; a skipped one passes as data
    assign wr_char = realign ? restored_char : in_char;

    lane_deinterleaver_stage #(
        .NLANES (NLANES)
    ) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .realign    (realign),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_char    (wr_char),
        .lane_data  (lane_data),
        .lane_valid (lane_valid)
    );

endmodule

// File: rtl/lane_deinterleaver_chk.sv
module lane_deinterleaver_chk
    import lane_deinterleaver_pkg::*;
#(
    parameter int NLANES    = 8,
    parameter int HOME_LANE = 0,
    localparam int DATA_W   = NLANES * CHAR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [8:0]        in_char,
    input logic [DATA_W-1:0] lane_data,
    input logic [NLANES-1:0] lane_valid,
    input logic              locked
);

    localparam logic [DATA_W-1:0] IDLE_ALL = {NLANES{COMMA_CHAR}};

    p_idle_unlocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (lane_data == IDLE_ALL && lane_valid == '0));

    p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    p_marker_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_char == ROT_MARK) |=> locked);

    p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid == '0) |-> $stable(lane_data));

    p_last_has_home_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid[NLANES-1] |-> lane_valid[HOME_LANE]);

    p_valid_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid != '0) |-> locked);

endmodule

bind lane_deinterleaver lane_deinterleaver_chk #(
    .NLANES    (NLANES),
    .HOME_LANE (HOME_LANE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_char    (in_char),
    .lane_data  (lane_data),
    .lane_valid (lane_valid),
    .locked     (locked)
);

// File: tb/lane_deinterleaver_test.sv
module lane_deinterleaver_test;
    import lane_deinterleaver_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 8;
    localparam int DW         = NL * CHAR_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [8:0]    in_char = '0;
    logic [DW-1:0] lane_data;
    logic [NL-1:0] lane_valid;
    logic          locked;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        string         req;
        logic [NL-1:0] mask;
        logic [DW-1:0] data;
    } exp_t;

    exp_t exp_q[$];

    lane_deinterleaver uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_char    (in_char),
        .lane_data  (lane_data),
        .lane_valid (lane_valid),
        .locked     (locked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic char_t dc(input int v);
        return {1'b0, 8'(v)};
    endfunction

    function automatic logic [DW-1:0] mk(input char_t c0, c1, c2, c3,
                                         input char_t c4, c5, c6, c7);
        return {c7, c6, c5, c4, c3, c2, c1, c0};
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_frame(input string req, input logic [NL-1:0] m,
                                input logic [DW-1:0] d);
        exp_t e;
        e.req = req; e.mask = m; e.data = d;
        exp_q.push_back(e);
    endtask

    task automatic send(input char_t c);
        @(negedge clk);
        in_valid = 1'b1;
        in_char  = c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_char  = '0;
        end
    endtask

    // monitor: every publish pulse is matched against the scoreboard
    always @(negedge clk) begin
        if (rst_n && lane_valid != '0) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8 unexpected publish actual %h expected none", lane_valid);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.req, " mask"}, DW'(lane_valid), DW'(e.mask));
                check({e.req, " data"}, lane_data, e.data);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] idle_all;
        idle_all = {NL{COMMA_CHAR}};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 locked", DW'(locked), DW'(0));
        check("R1 valid", DW'(lane_valid), DW'(0));
        check("R1 idle lanes", lane_data, idle_all);

        // R1: traffic before the first marker is discarded
        send(COMMA_CHAR); send(dc(1)); send(dc(2)); send(COMMA_CHAR); send(dc(3));
        idle(2);
        check("R1 still unlocked", DW'(locked), DW'(0));
        check("R1 idle after junk", lane_data, idle_all);

        // R2 R3 R4: first marker and a clean frame
        expect_frame("R3 R4 first frame", 8'hFF,
            mk(COMMA_CHAR, dc('h11), dc('h12), dc('h13), dc('h14), dc('h15), dc('h16), dc('h17)));
        send(ROT_MARK);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 lock after marker", DW'(locked), DW'(1));
        for (int i = 1; i < NL; i++) send(dc('h10 + i));
        idle(2);

        // R9: stall cycles inside a frame
        expect_frame("R9 stalled frame", 8'hFF,
            mk(COMMA_CHAR, dc('h21), dc('h22), dc('h23), dc('h24), dc('h25), dc('h26), dc('h27)));
        send(ROT_MARK); send(dc('h21)); idle(3);
        check("R9 no publish mid stall", lane_data,
            mk(COMMA_CHAR, dc('h11), dc('h12), dc('h13), dc('h14), dc('h15), dc('h16), dc('h17)));
        for (int i = 2; i < NL; i++) begin
            send(dc('h20 + i));
            if (i == 4) idle(2);
        end
        idle(2);

        // R5: K28.3 right after a marker is data on lane 1
        expect_frame("R5 skipped marker", 8'hFF,
            mk(COMMA_CHAR, ROT_MARK, dc('h32), dc('h33), dc('h34), dc('h35), dc('h36), dc('h37)));
        send(ROT_MARK); send(ROT_MARK);
        for (int i = 2; i < NL; i++) send(dc('h30 + i));
        idle(2);
        check("R2 lock held", DW'(locked), DW'(1));

        // R6 R7: spurious marker at lane 2, then genuine marker
        expect_frame("R6 partial frame", 8'h03,
            mk(COMMA_CHAR, dc('h41), dc('h32), dc('h33), dc('h34), dc('h35), dc('h36), dc('h37)));
        expect_frame("R7 shifted frame", 8'h3F,
            mk(COMMA_CHAR, dc('h43), dc('h44), dc('h45), dc('h46), dc('h47), dc('h36), dc('h37)));
        expect_frame("R7 realigned frame", 8'hFF,
            mk(COMMA_CHAR, dc('h51), dc('h52), dc('h53), dc('h54), dc('h55), dc('h56), dc('h57)));
        send(ROT_MARK); send(dc('h41)); send(ROT_MARK);
        for (int i = 3; i < NL; i++) send(dc('h40 + i));
        send(ROT_MARK);
        for (int i = 1; i < NL; i++) send(dc('h50 + i));
        idle(2);

        // R7: frame without a marker continues from lane 0
        expect_frame("R7 markerless frame", 8'hFF,
            mk(dc('h60), dc('h61), dc('h62), dc('h63), dc('h64), dc('h65), dc('h66), dc('h67)));
        for (int i = 0; i < NL; i++) send(dc('h60 + i));
        idle(5);

        // R8: outputs hold and valid is low after the last publish
        check("R8 hold data", lane_data,
            mk(dc('h60), dc('h61), dc('h62), dc('h63), dc('h64), dc('h65), dc('h66), dc('h67)));
        check("R8 valid low", DW'(lane_valid), DW'(0));
        check("R8 all frames seen", DW'(exp_q.size()), DW'(0));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule